// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm and Periodic Interrupt

This block keeps the time of day and a 100-year calendar for a processor subsystem. A 32.768 kHz enable pulse drives a binary prescaler. When the prescaler wraps, a seconds increment ripples through BCD seconds, minutes, hours, day of month, month and year. Month lengths follow the calendar, and a leap-year rule applies to February.

Software uses a small synchronous register port to set and read the time, to program a four-field alarm with a "don't care" bit on each field, and to choose a periodic interrupt rate. The periodic rate is tapped from the prescaler. Alarm and periodic events set sticky flags, which a read of the flag register clears. A single interrupt request is raised while any flag is set and its enable is on.

A backup-mode input models the system running from standby power. In that mode the register port ignores writes and the periodic source is stopped. The alarm keeps working, so it can still wake the system.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00. The control register, flag register, all alarm registers, `rdata` and `irq` are zero.
- R2: Seconds and minutes count 00 to 59 in BCD, and hours count 00 to 23. Each low digit carries from 9 to the high digit (for example 0x09 becomes 0x10). A field that is at its maximum returns to 00 and increments the next field.
- R3: Day of month wraps to 0x01 after the last day of the month. April, June, September and November have 0x30 days. February has 0x29 days when the BCD year is divisible by 4, otherwise 0x28. All other months have 0x31 days. Month 0x12 wraps to 0x01, and year 0x99 wraps to 0x00.
- R4: A seconds increment occurs every 2^DIV_BITS enabled ticks (32768 by default). A write to any time register (addresses 0x0 to 0x5) reloads the prescaler to zero, so the next increment comes exactly 2^DIV_BITS ticks after that write.
- R5: Each alarm register (0x6 seconds, 0x7 minutes, 0x8 hours, 0x9 day) holds a BCD value in bits 6:0 and a "don't care" bit in bit 7. At each seconds increment, the alarm flag is set when every field without the "don't care" bit equals the newly counted time. With all four fields marked "don't care", the alarm fires every second.
- R6: Control bits 3:0 hold a rate code c. Code 0 stops the periodic source. Code c from 1 to DIV_BITS sets the periodic flag once every 2^(c-1) ticks. Codes above DIV_BITS set it once per second. The phase is measured from the last prescaler reload.
- R7: The flag register (0xB) holds the alarm flag in bit 0 and the periodic flag in bit 1. Each flag stays set until the flag register is read. That read returns the flags and then clears them, unless a new event arrives in the same cycle, in which case the flag stays set.
- R8: `irq` is high exactly while (flag bit 0 AND control bit 4) OR (flag bit 1 AND control bit 5).
- R9: While `backup` is high, all register writes are ignored and the periodic flag is never set. Alarm matches still set the alarm flag and raise `irq`.
- R10: A read with `rd` high presents the addressed register on `rdata` in the following cycle. The register map is 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 day, 0x4 month, 0x5 year, 0x6 to 0x9 alarm, 0xA control (bits 5:0) and 0xB flags. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| backup | input | 1 | Backup mode: writes blocked, periodic source stopped |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are calendar boundaries such as the leap day, month ends and the century wrap. With a full-length prescaler they are many real seconds apart. The bench therefore builds the block with a short prescaler. It loads the time one second before each boundary, which also reloads the prescaler and fixes the phase, and then reads every field back. Alarm matches, periodic taps and backup-mode blocking are timed the same way, from the last time write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [3:0] ADR_SEC   = 4'h0;
  localparam logic [3:0] ADR_MIN   = 4'h1;
  localparam logic [3:0] ADR_HOUR  = 4'h2;
  localparam logic [3:0] ADR_DATE  = 4'h3;
  localparam logic [3:0] ADR_MONTH = 4'h4;
  localparam logic [3:0] ADR_YEAR  = 4'h5;
  localparam logic [3:0] ADR_ALM0  = 4'h6;
  localparam logic [3:0] ADR_ALM3  = 4'h9;
  localparam logic [3:0] ADR_CTRL  = 4'hA;
  localparam logic [3:0] ADR_FLAG  = 4'hB;

  // Add one to a two-digit BCD value (no wrap handling at 99).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // True when the two-digit BCD year is a multiple of four.
  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] b;
    b = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  // Last day of a BCD month, as a BCD value.
  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    case (m)
      8'h02:                      r = leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS = 15,
  parameter int RATE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              reload,
  input  logic [RATE_W-1:0] rate,
  output logic              sec_tick,
  output logic              per_evt
);

  logic [DIV_BITS-1:0] div_q;
  logic [DIV_BITS-1:0] tap_mask;

  // Bit g of the tap mask takes part when the selected period exceeds 2^g.
  for (genvar g = 0; g < DIV_BITS; g++) begin : g_tap
    assign tap_mask[g] = (32'(rate) > 32'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (rst || reload) div_q <= '0;
    else if (tick_en)  div_q <= div_q + 1'b1;
  end

  assign sec_tick = tick_en && !reload && (&div_q);
  assign per_evt  = tick_en && !reload && (rate != '0) &&
                    ((div_q & tap_mask) == tap_mask);

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sec_tick,
  input  logic      wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output rtc_time_t cur,
  output rtc_time_t nxt
);

  logic c_min, c_hour, c_day, c_mon, c_year;

  // Carry chain from seconds up to years.
  always_comb begin
    c_min  = (cur.sec  >= 8'h59);
    c_hour = c_min  && (cur.min  >= 8'h59);
    c_day  = c_hour && (cur.hour >= 8'h23);
    c_mon  = c_day  && (cur.date >= month_len(cur.month, cur.year));
    c_year = c_mon  && (cur.month >= 8'h12);

    nxt       = cur;
    nxt.sec   = c_min  ? 8'h00 : bcd_inc(cur.sec);
    nxt.min   = c_hour ? 8'h00 : (c_min  ? bcd_inc(cur.min)   : cur.min);
    nxt.hour  = c_day  ? 8'h00 : (c_hour ? bcd_inc(cur.hour)  : cur.hour);
    nxt.date  = c_mon  ? 8'h01 : (c_day  ? bcd_inc(cur.date)  : cur.date);
    nxt.month = c_year ? 8'h01 : (c_mon  ? bcd_inc(cur.month) : cur.month);
    if (c_year) nxt.year = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '{year: 8'h00, month: 8'h01, date: 8'h01,
               hour: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (wr_en) begin
      case (wr_sel)
        3'd0:    cur.sec   <= wr_data;
        3'd1:    cur.min   <= wr_data;
        3'd2:    cur.hour  <= wr_data;
        3'd3:    cur.date  <= wr_data;
        3'd4:    cur.month <= wr_data;
        default: cur.year  <= wr_data;
      endcase
    end else if (sec_tick) begin
      cur <= nxt;
    end
  end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int NALM = 4
) (
  input  rtc_time_t             t,
  input  logic [NALM-1:0][7:0]  alm,
  output logic                  hit
);

  logic [NALM-1:0][7:0] fld;
  logic [NALM-1:0]      ok;

  assign fld = {t.date, t.hour, t.min, t.sec};

  // Bit 7 of each alarm byte means "ignore this field".
  for (genvar g = 0; g < NALM; g++) begin : g_cmp
    assign ok[g] = alm[g][7] || (alm[g][6:0] == fld[g][6:0]);
  end

  assign hit = &ok;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       backup,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  output logic       irq
);

  localparam int NALM   = 4;
  localparam int RATE_W = 4;
  localparam int CTRL_W = RATE_W + 2;

  rtc_time_t            cur, nxt;
  logic                 wr_ok, time_wr, sec_tick, per_evt, hit, alarm_evt;
  logic [NALM-1:0][7:0] alm_q;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_n;
  logic [1:0]           flags_q, flags_n;
  logic [7:0]           rd_mux;

  assign wr_ok   = wr && !backup;
  assign time_wr = wr_ok && (addr <= ADR_YEAR);

  rtc_prescaler #(.DIV_BITS(DIV_BITS), .RATE_W(RATE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .reload   (time_wr),
    .rate     (ctrl_q[RATE_W-1:0]),
    .sec_tick (sec_tick),
    .per_evt  (per_evt)
  );

  rtc_timekeeper u_tk (
    .clk      (clk),
    .rst      (rst),
    .sec_tick (sec_tick),
    .wr_en    (time_wr),
    .wr_sel   (addr[2:0]),
    .wr_data  (wdata),
    .cur      (cur),
    .nxt      (nxt)
  );

  rtc_alarm #(.NALM(NALM)) u_alm (
    .t   (nxt),
    .alm (alm_q),
    .hit (hit)
  );

  // Match is judged against the time that the increment is about to load.
  assign alarm_evt = sec_tick && hit;

  for (genvar g = 0; g < NALM; g++) begin : g_alm_reg
    always_ff @(posedge clk) begin
      if (rst) alm_q[g] <= 8'h00;
      else if (wr_ok && (addr == ADR_ALM0 + 4'(g))) alm_q[g] <= wdata;
    end
  end

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ok && addr == ADR_CTRL) ctrl_n = wdata[CTRL_W-1:0];
    flags_n = flags_q;
    if (rd && addr == ADR_FLAG) flags_n = 2'b00;
    if (alarm_evt)              flags_n[0] = 1'b1;
    if (per_evt && !backup)     flags_n[1] = 1'b1;
  end

  always_comb begin
    case (addr)
      ADR_SEC:   rd_mux = cur.sec;
      ADR_MIN:   rd_mux = cur.min;
      ADR_HOUR:  rd_mux = cur.hour;
      ADR_DATE:  rd_mux = cur.date;
      ADR_MONTH: rd_mux = cur.month;
      ADR_YEAR:  rd_mux = cur.year;
      4'h6:      rd_mux = alm_q[0];
      4'h7:      rd_mux = alm_q[1];
      4'h8:      rd_mux = alm_q[2];
      ADR_ALM3:  rd_mux = alm_q[3];
      ADR_CTRL:  rd_mux = {{(8-CTRL_W){1'b0}}, ctrl_q};
      ADR_FLAG:  rd_mux = {6'd0, flags_q};
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      flags_q <= 2'b00;
      rdata   <= 8'h00;
      irq     <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      flags_q <= flags_n;
      if (rd) rdata <= rd_mux;
      irq     <= (flags_n[0] && ctrl_n[RATE_W]) || (flags_n[1] && ctrl_n[RATE_W+1]);
    end
  end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic        clk,
  input logic        rst,
  input logic        backup,
  input logic        wr,
  input logic        rd,
  input logic [3:0]  addr,
  input logic        irq,
  input logic [1:0]  flags,
  input logic [5:0]  ctrl,
  input logic [31:0] alm,
  input logic [7:0]  sec,
  input logic [7:0]  min,
  input logic [7:0]  hour,
  input logic [7:0]  date,
  input logic [7:0]  month,
  input logic [7:0]  year,
  input logic        sec_tick,
  input logic        per_evt
);

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && sec == 8'h59) |=> (sec == 8'h00));

  p_min_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && sec == 8'h59 && min == 8'h59) |=> (min == 8'h00));

  p_century_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && sec == 8'h59 && min == 8'h59 && hour == 8'h23 &&
     date == 8'h31 && month == 8'h12 && year == 8'h99)
    |=> (year == 8'h00 && month == 8'h01 && date == 8'h01));

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && !backup && addr <= 4'h5) |=> !sec_tick);

  p_per_off_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl[3:0] == 4'h0 && !flags[1]) |=> !flags[1]);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == 4'hB && !sec_tick && !per_evt) |=> (flags == 2'b00));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq == ((flags[0] && ctrl[4]) || (flags[1] && ctrl[5])));

  p_backup_hold_r9: assert property (@(posedge clk) disable iff (rst)
    backup |=> ($stable(ctrl) && $stable(alm)));

  p_backup_noper_r9: assert property (@(posedge clk) disable iff (rst)
    (backup && !flags[1]) |=> !flags[1]);

endmodule

bind rtc_calendar rtc_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .backup   (backup),
  .wr       (wr),
  .rd       (rd),
  .addr     (addr),
  .irq      (irq),
  .flags    (flags_q),
  .ctrl     (ctrl_q),
  .alm      (alm_q),
  .sec      (cur.sec),
  .min      (cur.min),
  .hour     (cur.hour),
  .date     (cur.date),
  .month    (cur.month),
  .year     (cur.year),
  .sec_tick (sec_tick),
  .per_evt  (per_evt)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_BITS   = 8;
  localparam int SEC_CYC    = 1 << DIV_BITS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       backup = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_val_q[$];
  bit         exp_chk_q[$];
  string      exp_tag_q[$];
  logic       rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar #(.DIV_BITS(DIV_BITS)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .backup(backup),
    .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .irq(irq)
  );

  // Monitor: each captured read is compared one cycle later.
  always @(posedge clk) rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen && exp_val_q.size() > 0) begin
      logic [7:0] e;
      bit         c;
      string      t;
      e = exp_val_q.pop_front();
      c = exp_chk_q.pop_front();
      t = exp_tag_q.pop_front();
      if (c) begin
        checks++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s actual=%02h expected=%02h", t, rdata, e);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
    addr = a; rd = 1'b1;
    exp_val_q.push_back(e); exp_chk_q.push_back(1'b1); exp_tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_read_nc(input logic [3:0] a);
    addr = a; rd = 1'b1;
    exp_val_q.push_back(8'h00); exp_chk_q.push_back(1'b0); exp_tag_q.push_back("");
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    bus_write(4'h5, y);
    bus_write(4'h4, mo);
    bus_write(4'h3, d);
    bus_write(4'h2, h);
    bus_write(4'h1, mi);
    bus_write(4'h0, s);
  endtask

  task automatic check_time(input logic [7:0] y, mo, d, h, mi, s, input string tag);
    bus_read(4'h0, s,  {tag, " sec"});
    bus_read(4'h1, mi, {tag, " min"});
    bus_read(4'h2, h,  {tag, " hour"});
    bus_read(4'h3, d,  {tag, " date"});
    bus_read(4'h4, mo, {tag, " month"});
    bus_read(4'h5, y,  {tag, " year"});
  endtask

  task automatic set_alarm(input logic [7:0] s, mi, h, d);
    bus_write(4'h6, s);
    bus_write(4'h7, mi);
    bus_write(4'h8, h);
    bus_write(4'h9, d);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    tick_en = 1'b1;
    wait_cyc(1);

    // R1: reset state
    check_irq(1'b0, "R1 reset");
    check_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1 reset");
    bus_read(4'hA, 8'h00, "R1 ctrl");
    bus_read(4'hB, 8'h00, "R1 flags");
    bus_read(4'h6, 8'h00, "R1 alarm sec");
    bus_read(4'hF, 8'h00, "R10 unmapped");

    // R4 + R2: one-second spacing after a reload, digit carry 09 -> 10
    set_time(8'h07, 8'h06, 8'h15, 8'h13, 8'h45, 8'h09);
    wait_cyc(SEC_CYC - 16);
    bus_read(4'h0, 8'h09, "R4 before increment");
    wait_cyc(30);
    check_time(8'h07, 8'h06, 8'h15, 8'h13, 8'h45, 8'h10, "R2 digit carry");

    // R2: minute carry
    set_time(8'h07, 8'h06, 8'h15, 8'h13, 8'h45, 8'h59);
    wait_cyc(SEC_CYC + 10);
    check_time(8'h07, 8'h06, 8'h15, 8'h13, 8'h46, 8'h00, "R2 minute carry");

    // R3: leap February 28 -> 29
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC_CYC + 10);
    check_time(8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, "R3 leap feb28");

    // R3: leap February 29 -> March 1
    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC_CYC + 10);
    check_time(8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, "R3 leap feb29");

    // R3: common year February 28 -> March 1
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC_CYC + 10);
    check_time(8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, "R3 common feb");

    // R3: thirty-day month
    set_time(8'h31, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC_CYC + 10);
    check_time(8'h31, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00, "R3 april end");

    // R3: century wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC_CYC + 10);
    check_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R3 century wrap");

    // R5/R7/R8: every-second alarm (all fields ignored)
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    bus_write(4'hA, 8'h10);
    set_time(8'h10, 8'h03, 8'h05, 8'h11, 8'h20, 8'h30);
    bus_read_nc(4'hB);
    wait_cyc(SEC_CYC - 20);
    check_irq(1'b0, "R8 no event yet");
    bus_read(4'hB, 8'h00, "R5 before second");
    wait_cyc(25);
    check_irq(1'b1, "R8 alarm irq");
    bus_read(4'hB, 8'h01, "R5 every second");
    check_irq(1'b0, "R7 irq after clear");
    bus_read(4'hB, 8'h00, "R7 read clears");

    // R5: minute match with seconds, hour and day ignored except seconds
    set_alarm(8'h00, 8'h31, 8'h80, 8'h80);
    set_time(8'h10, 8'h03, 8'h05, 8'h10, 8'h30, 8'h58);
    bus_read_nc(4'hB);
    wait_cyc(SEC_CYC + 10);
    check_irq(1'b0, "R5 mismatch irq");
    bus_read(4'hB, 8'h00, "R5 mismatch at :59");
    wait_cyc(SEC_CYC);
    check_irq(1'b1, "R5 match irq");
    bus_read(4'hB, 8'h01, "R5 match at 31:00");

    // R8: alarm flag without enable keeps irq low
    bus_write(4'hA, 8'h00);
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    set_time(8'h10, 8'h03, 8'h05, 8'h10, 8'h30, 8'h00);
    bus_read_nc(4'hB);
    wait_cyc(SEC_CYC + 10);
    check_irq(1'b0, "R8 masked enable");
    bus_read(4'hB, 8'h01, "R8 flag without enable");
    bus_write(4'h9, 8'h00);
    bus_read_nc(4'hB);

    // R6: code 8 -> period 128 ticks after reload
    set_time(8'h10, 8'h03, 8'h05, 8'h10, 8'h30, 8'h00);
    bus_write(4'hA, 8'h28);
    bus_read_nc(4'hB);
    wait_cyc(100);
    check_irq(1'b0, "R6 before tap");
    bus_read(4'hB, 8'h00, "R6 before tap");
    wait_cyc(30);
    check_irq(1'b1, "R8 periodic irq");
    bus_read(4'hB, 8'h02, "R6 first period");
    bus_read(4'hB, 8'h00, "R7 periodic cleared");
    wait_cyc(130);
    bus_read(4'hB, 8'h02, "R6 second period");

    // R6: code above DIV_BITS -> once per second
    set_time(8'h10, 8'h03, 8'h05, 8'h10, 8'h30, 8'h00);
    bus_write(4'hA, 8'h2F);
    bus_read_nc(4'hB);
    wait_cyc(200);
    bus_read(4'hB, 8'h00, "R6 clamp early");
    wait_cyc(70);
    bus_read(4'hB, 8'h02, "R6 clamp once per second");

    // R6: code 1 -> every tick
    bus_write(4'hA, 8'h01);
    bus_read_nc(4'hB);
    bus_read(4'hB, 8'h02, "R6 code 1 every tick");

    // R6: code 0 stops the periodic source
    set_time(8'h10, 8'h03, 8'h05, 8'h10, 8'h30, 8'h00);
    bus_write(4'hA, 8'h20);
    bus_read_nc(4'hB);
    wait_cyc(300);
    check_irq(1'b0, "R6 code 0 irq");
    bus_read(4'hB, 8'h00, "R6 code 0 no flag");

    // R9: backup mode
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    set_time(8'h10, 8'h03, 8'h05, 8'h08, 8'h15, 8'h20);
    bus_write(4'hA, 8'h32);
    backup = 1'b1;
    bus_read_nc(4'hB);
    bus_read(4'hB, 8'h00, "R9 periodic blocked");
    bus_write(4'hA, 8'h00);
    bus_write(4'h0, 8'h00);
    bus_write(4'h9, 8'h00);
    bus_read(4'hA, 8'h32, "R9 ctrl write ignored");
    bus_read(4'h9, 8'h80, "R9 alarm write ignored");
    wait_cyc(SEC_CYC);
    check_irq(1'b1, "R9 alarm wakes");
    bus_read(4'hB, 8'h01, "R9 alarm flag in backup");
    bus_read(4'h0, 8'h21, "R9 time write ignored");
    backup = 1'b0;

    wait_cyc(4);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule